// File: doc/BRIEF.md
# Timer/Watchdog Down-Counter

This block is an 8-bit down-counter for timekeeping. It works either as a periodic timer that restarts by itself, or as a watchdog that stops at zero and waits to be serviced. Every register runs on one system clock. The count moves only on an enable tick, and that tick is qualified twice. First, one of four rate-enable strobes is picked by a select input. Second, a gate source that depends on the mode must also be high: any timer gate bit in timer mode, or the watchdog gate in watchdog mode.

Several trigger sources copy the programmed reload value into the counter, and a load always wins over a decrement in the same cycle. The trigger sources are:
- a software trigger
- an initial-value load strobe
- a watchdog service (kick)
- an external hardware trigger, which is synchronised and edge-detected first

When a tick arrives while the count is zero, the block raises a one-cycle underflow pulse and handles the count according to the mode. A timer reloads in that same clock edge, so the count never passes through 0xFF. A watchdog stays at zero. A second output repeats the underflow pulse exactly two clock cycles later.

Nothing moves unless both the initialised flag and the run control are high.

Top module: `tmr_wdog_counter`

## Requirements
- R1: When rst_n is low at a rising clock edge, that edge sets count, underflow and underflow_dly2 to zero.
- R2: While init_done or run is low, count holds its value, no trigger loads it and no underflow pulse is produced.
- R3: A tick is rate_en[rate_sel] AND the mode gate. The mode gate is any bit of tmr_gate when mode=0 (timer) and wd_gate when mode=1 (watchdog). A tick on a non-zero count with no load decrements count by one at that edge.
- R4: When active, a high on sw_trig, init_load or wd_kick at a clock edge loads reload_val into count at that edge. This load wins over a tick in the same cycle.
- R5: In timer mode, a tick taken at count zero loads reload_val at that same edge, so count never shows 0xFF between zero and the reload value.
- R6: In watchdog mode, a tick taken at count zero leaves count at zero.
- R7: underflow is high for the one cycle after an edge at which count was zero, a tick was taken, the block was active and no load occurred. In timer mode it is high in the same cycle in which count first shows the reload value.
- R8: In watchdog mode, underflow fires only once while count sits at zero. It can fire again only after a load followed by a new countdown to zero.
- R9: underflow_dly2 equals the value that underflow had two clock cycles earlier.
- R10: hw_trig passes through a two-flop synchroniser and a rising-edge detector. count shows reload_val after the third rising clock edge at which hw_trig is sampled high. Holding hw_trig high gives exactly one load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 1 | 0 = auto-reload timer, 1 = hold-at-zero watchdog |
| rate_en | input | 4 | Rate-enable strobes |
| rate_sel | input | 2 | Index of the rate strobe in use |
| tmr_gate | input | 2 | Gate sources used in timer mode (ORed) |
| wd_gate | input | 1 | Gate source used in watchdog mode |
| init_done | input | 1 | Initialised flag; must be high for any activity |
| run | input | 1 | Start/stop control; must be high for any activity |
| reload_val | input | 8 | Programmed reload value |
| sw_trig | input | 1 | Software load trigger |
| hw_trig | input | 1 | Asynchronous hardware load trigger |
| init_load | input | 1 | Initial-value load strobe |
| wd_kick | input | 1 | Watchdog service load |
| count | output | 8 | Current counter value |
| underflow | output | 1 | One-cycle pulse on countdown completion |
| underflow_dly2 | output | 1 | underflow delayed by two cycles |

## Verification
The bench checks the count on every cycle across the zero-to-reload step in timer mode. A design that decrements past zero and reloads one tick later would show 0xFF there and raise underflow a cycle late. In watchdog mode the bench keeps ticking at zero to catch a count that wraps or an underflow that repeats, and it then services the watchdog to confirm the pulse can fire again. It drives a load and a tick in the same cycle, uses an unselected rate strobe and the other mode's gate, and clears the run and initialised controls, since each of these exposes a wrong priority or a missing gating term. It holds the hardware trigger high for many cycles, which exposes both a missing edge detector (repeated loads) and a synchroniser of the wrong depth (early or late load).

// File: rtl/tmr_pkg.sv
// Package: shared types for the timer/watchdog counter.
// Assumes a single-bit mode select driven by the surrounding logic.
package tmr_pkg;
    typedef enum logic {
        MODE_TIMER    = 1'b0,
        MODE_WATCHDOG = 1'b1
    } tmr_mode_e;
endpackage

// File: rtl/tmr_tick_select.sv
// Module: tmr_tick_select
// Builds the single-cycle decrement tick from the selected rate strobe and
// the gate source of the current mode.
// Assumes NUM_RATES is a power of two so rate_sel never indexes out of range.
module tmr_tick_select
    import tmr_pkg::*;
#(
    parameter int NUM_RATES     = 4,
    parameter int NUM_TMR_GATES = 2,
    localparam int SEL_W        = $clog2(NUM_RATES)
) (
    input  tmr_mode_e                mode,
    input  logic [NUM_RATES-1:0]     rate_en,
    input  logic [SEL_W-1:0]         rate_sel,
    input  logic [NUM_TMR_GATES-1:0] tmr_gate,
    input  logic                     wd_gate,
    output logic                     tick
);
    logic gate_ok;

    // Pick the gate that belongs to the current mode.
    always_comb begin
        if (mode == MODE_WATCHDOG) gate_ok = wd_gate;
        else                       gate_ok = |tmr_gate;
    end

    // The tick needs both the selected rate strobe and the gate.
    always_comb begin
        tick = rate_en[rate_sel] & gate_ok;
    end
endmodule

// File: rtl/tmr_trig_sync.sv
// Module: tmr_trig_sync
// Brings an asynchronous trigger level into the clock domain and emits one
// clock-wide pulse on each rising edge of it.
// Assumes the trigger stays high for at least two clock cycles.
module tmr_trig_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_async,
    output logic trig_pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Synchroniser chain, plus the previous synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], trig_async};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Rising-edge detect on the synchronised level.
    always_comb begin
        trig_pulse = sync_q[SYNC_STAGES-1] & ~prev_q;
    end
endmodule

// File: rtl/tmr_count_core.sv
// Module: tmr_count_core
// The down-counter with load priority, the zero-time action of each mode,
// the registered underflow pulse and its delay line.
// Assumes tick and load_req are synchronous single-cycle qualifiers.
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int DLY_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmr_mode_e        mode,
    input  logic             active,
    input  logic             tick,
    input  logic             load_req,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             underflow,
    output logic             underflow_dly2
);
    logic [CNT_W-1:0]      cnt_q;
    logic                  uf_q;
    logic                  wd_fired_q;
    logic [DLY_STAGES-1:0] dly_q;
    logic                  at_zero;
    logic                  uf_now;

    // Detect zero and qualify the completion event for this cycle.
    always_comb begin
        at_zero = (cnt_q == '0);
        uf_now  = active & tick & at_zero & ~load_req &
                  ~((mode == MODE_WATCHDOG) & wd_fired_q);
    end

    // Counter: a load wins, then a tick at zero, then a plain decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (active) begin
            if (load_req)                        cnt_q <= reload_val;
            else if (tick && at_zero && mode == MODE_TIMER)
                                                 cnt_q <= reload_val;
            else if (tick && !at_zero)           cnt_q <= cnt_q - 1'b1;
        end
    end

    // Watchdog latch: set after the first underflow, cleared by a load.
    always_ff @(posedge clk) begin
        if (!rst_n)                          wd_fired_q <= 1'b0;
        else if (active && load_req)         wd_fired_q <= 1'b0;
        else if (uf_now && mode == MODE_WATCHDOG) wd_fired_q <= 1'b1;
    end

    // Registered underflow and its fixed-length delay line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uf_q  <= 1'b0;
            dly_q <= '0;
        end else begin
            uf_q  <= uf_now;
            dly_q <= {dly_q[DLY_STAGES-2:0], uf_q};
        end
    end

    assign count          = cnt_q;
    assign underflow      = uf_q;
    assign underflow_dly2 = dly_q[DLY_STAGES-1];
endmodule

// File: rtl/tmr_wdog_counter.sv
// Module: tmr_wdog_counter (top)
// Dual-mode timer/watchdog down-counter. It combines the tick selection,
// the hardware trigger synchroniser and the counting core.
// Assumes one system clock; rate_en strobes are synchronous enables.
module tmr_wdog_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W         = 8,
    parameter int NUM_RATES     = 4,
    parameter int NUM_TMR_GATES = 2,
    localparam int SEL_W        = $clog2(NUM_RATES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode,
    input  logic [NUM_RATES-1:0]     rate_en,
    input  logic [SEL_W-1:0]         rate_sel,
    input  logic [NUM_TMR_GATES-1:0] tmr_gate,
    input  logic                     wd_gate,
    input  logic                     init_done,
    input  logic                     run,
    input  logic [CNT_W-1:0]         reload_val,
    input  logic                     sw_trig,
    input  logic                     hw_trig,
    input  logic                     init_load,
    input  logic                     wd_kick,
    output logic [CNT_W-1:0]         count,
    output logic                     underflow,
    output logic                     underflow_dly2
);
    tmr_mode_e mode_e;
    logic      tick;
    logic      hw_pulse;
    logic      active;
    logic      load_req;

    // Decode the mode and combine the gating and trigger terms.
    always_comb begin
        mode_e   = tmr_mode_e'(mode);
        active   = init_done & run;
        load_req = sw_trig | hw_pulse | init_load | wd_kick;
    end

    tmr_tick_select #(
        .NUM_RATES     (NUM_RATES),
        .NUM_TMR_GATES (NUM_TMR_GATES)
    ) i_tick (
        .mode     (mode_e),
        .rate_en  (rate_en),
        .rate_sel (rate_sel),
        .tmr_gate (tmr_gate),
        .wd_gate  (wd_gate),
        .tick     (tick)
    );

    tmr_trig_sync #(
        .SYNC_STAGES (2)
    ) i_hw_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_async (hw_trig),
        .trig_pulse (hw_pulse)
    );

    tmr_count_core #(
        .CNT_W      (CNT_W),
        .DLY_STAGES (2)
    ) i_core (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode           (mode_e),
        .active         (active),
        .tick           (tick),
        .load_req       (load_req),
        .reload_val     (reload_val),
        .count          (count),
        .underflow      (underflow),
        .underflow_dly2 (underflow_dly2)
    );
endmodule

// File: rtl/tmr_wdog_counter_chk.sv
// Module: tmr_wdog_counter_chk
// Port-level properties of the timer/watchdog counter. It is bound to the
// top module. Assumes it sees the same clock and reset as the design.
module tmr_wdog_counter_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode,
    input logic             init_done,
    input logic             run,
    input logic [CNT_W-1:0] reload_val,
    input logic             sw_trig,
    input logic             init_load,
    input logic             wd_kick,
    input logic [CNT_W-1:0] count,
    input logic             underflow,
    input logic             underflow_dly2
);
    logic warm;
    logic rst_seen;

    // Track whether one clean cycle has passed since reset.
    always_ff @(posedge clk) begin
        warm     <= rst_n;
        rst_seen <= !rst_n;
    end

    // R1: the edge after reset was sampled low leaves all outputs at zero.
    always @(posedge clk) begin
        if (rst_seen)
            assert_reset_clear_R1: assert (count == '0 && !underflow && !underflow_dly2);
    end

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        warm && !(init_done && run) |=> $stable(count) && !underflow);

    assert_load_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
        init_done && run && (sw_trig || init_load || wd_kick) |=> count == $past(reload_val));

    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        warm && $past(count) == '0 && count != '0 |-> count == $past(reload_val));

    assert_wd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        init_done && run && mode && count == '0 && !sw_trig && !init_load && !wd_kick
        |=> count == '0 || count == $past(reload_val));

    assert_uf_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        warm && underflow |-> $past(count) == '0);

    assert_wd_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        warm && $past(mode) && underflow |=> !underflow);

    assert_delay_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> ##1 underflow_dly2);

    assert_delay_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !underflow |=> ##1 !underflow_dly2);
endmodule

bind tmr_wdog_counter tmr_wdog_counter_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_tmr_wdog_counter.sv
// Directed bench for tmr_wdog_counter. Inputs are driven and outputs are
// sampled 1 ns after each rising edge.
module test_tmr_wdog_counter;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode;
    logic [3:0] rate_en;
    logic [1:0] rate_sel;
    logic [1:0] tmr_gate;
    logic       wd_gate;
    logic       init_done;
    logic       run;
    logic [7:0] reload_val;
    logic       sw_trig;
    logic       hw_trig;
    logic       init_load;
    logic       wd_kick;
    logic [7:0] count;
    logic       underflow;
    logic       underflow_dly2;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    tmr_wdog_counter i_tmr_wdog_counter (
        .clk(clk), .rst_n(rst_n), .mode(mode), .rate_en(rate_en),
        .rate_sel(rate_sel), .tmr_gate(tmr_gate), .wd_gate(wd_gate),
        .init_done(init_done), .run(run), .reload_val(reload_val),
        .sw_trig(sw_trig), .hw_trig(hw_trig), .init_load(init_load),
        .wd_kick(wd_kick), .count(count), .underflow(underflow),
        .underflow_dly2(underflow_dly2)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        cyc(2);
        chk("R1 count", count, 0);
        chk("R1 underflow", underflow, 0);
        chk("R1 dly2", underflow_dly2, 0);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic t_timer;
        reload_val = 8'd5; sw_trig = 1'b1;
        cyc(1);
        sw_trig = 1'b0;
        chk("R4 sw load", count, 5);
        tmr_gate = 2'b01;
        for (int i = 4; i >= 0; i--) begin
            cyc(1);
            chk("R3 decrement", count, i);
            chk("R7 no early uf", underflow, 0);
        end
        cyc(1);
        chk("R5 reload no wrap", count, 5);
        chk("R7 underflow", underflow, 1);
        cyc(1);
        chk("R5 after reload", count, 4);
        chk("R9 dly not early", underflow_dly2, 0);
        cyc(1);
        chk("R9 dly2", underflow_dly2, 1);
        cyc(1);
        chk("R9 dly2 single", underflow_dly2, 0);
        tmr_gate = 2'b00;
        cyc(1);
    endtask

    task automatic t_priority;
        reload_val = 8'd8; sw_trig = 1'b1; tmr_gate = 2'b10;
        cyc(1);
        sw_trig = 1'b0;
        chk("R4 load beats tick", count, 8);
        reload_val = 8'd20; init_load = 1'b1;
        cyc(1);
        init_load = 1'b0; tmr_gate = 2'b00;
        chk("R4 init load", count, 20);
    endtask

    task automatic t_gating;
        run = 1'b0; tmr_gate = 2'b01; sw_trig = 1'b1; reload_val = 8'd50;
        cyc(2);
        chk("R2 run low", count, 20);
        run = 1'b1; init_done = 1'b0;
        cyc(2);
        chk("R2 init low", count, 20);
        chk("R2 no underflow", underflow, 0);
        sw_trig = 1'b0; tmr_gate = 2'b00; init_done = 1'b1;
        cyc(1);
    endtask

    task automatic t_rate;
        rate_en = 4'b0010; rate_sel = 2'd2; tmr_gate = 2'b01;
        cyc(2);
        chk("R3 unselected rate", count, 20);
        rate_en = 4'b0100;
        cyc(2);
        chk("R3 selected rate", count, 18);
        tmr_gate = 2'b00; wd_gate = 1'b1;
        cyc(1);
        chk("R3 wd gate in timer mode", count, 18);
        wd_gate = 1'b0; rate_en = 4'b1111; rate_sel = 2'd0;
    endtask

    task automatic t_watchdog;
        mode = 1'b1; reload_val = 8'd2; wd_kick = 1'b1;
        cyc(1);
        wd_kick = 1'b0;
        chk("R4 kick load", count, 2);
        tmr_gate = 2'b11;
        cyc(1);
        chk("R3 timer gate in wd mode", count, 2);
        tmr_gate = 2'b00; wd_gate = 1'b1;
        cyc(1); chk("R3 wd decrement", count, 1);
        cyc(1); chk("R3 wd reach zero", count, 0);
        chk("R7 no uf on reaching zero", underflow, 0);
        cyc(1);
        chk("R6 hold zero", count, 0);
        chk("R7 wd underflow", underflow, 1);
        cyc(1);
        chk("R8 single pulse", underflow, 0);
        for (int i = 0; i < 3; i++) begin
            cyc(1);
            chk("R8 no refire", underflow, 0);
            chk("R6 still zero", count, 0);
        end
        wd_kick = 1'b1;
        cyc(1);
        wd_kick = 1'b0;
        chk("R4 kick at zero", count, 2);
        cyc(2);
        chk("R6 zero again", count, 0);
        cyc(1);
        chk("R8 refire after kick", underflow, 1);
        wd_gate = 1'b0; mode = 1'b0;
        cyc(1);
    endtask

    task automatic t_hw;
        reload_val = 8'd9; hw_trig = 1'b1;
        cyc(2);
        chk("R10 not early", count, 0);
        cyc(1);
        chk("R10 hw load", count, 9);
        tmr_gate = 2'b01;
        cyc(2);
        chk("R10 single load", count, 7);
        tmr_gate = 2'b00; hw_trig = 1'b0;
        cyc(3);
    endtask

    task automatic t_reset_mid;
        reload_val = 8'd33; sw_trig = 1'b1;
        cyc(1);
        sw_trig = 1'b0; rst_n = 1'b0;
        cyc(1);
        chk("R1 mid-run reset", count, 0);
        rst_n = 1'b1;
        cyc(1);
    endtask

    initial begin
        rst_n = 1'b0; mode = 1'b0; rate_en = 4'b1111; rate_sel = 2'd0;
        tmr_gate = 2'b00; wd_gate = 1'b0; init_done = 1'b1; run = 1'b1;
        reload_val = 8'd0; sw_trig = 1'b0; hw_trig = 1'b0;
        init_load = 1'b0; wd_kick = 1'b0;
        #1;
        t_reset();
        t_timer();
        t_priority();
        t_gating();
        t_rate();
        t_watchdog();
        t_hw();
        t_reset_mid();
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog timeout actual=0 expected=1");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule